// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a flash device. It decides when a program or erase operation that is already running in the flash has finished. A one-cycle start pulse loads four things: the kind of operation, the word that was written, the address to watch and a limit on the number of status reads. The block then reads that address over and over through a request/acknowledge read port. On each word it looks at the completion flag on bit 7.

While a program operation runs, the flag reads as the inverse of bit 7 of the written word. While an erase runs, the flag reads as 0. When the flag matches its target value, the other bits of that same word cannot yet be trusted. The block therefore always issues one more confirming read, and it judges the outcome only on that word. The operation passes only if the whole confirming word equals the expected word. For a program, the expected word is the written data. For an erase, it is all ones.

A program attempt to a protected region ends with the old data still in place, so it shows up as a confirm mismatch. If the flag never matches within the limit, the block ends with a timeout. For an erase, the caller must give an address inside a region that is being erased and is not protected.

Top module: `flash_done_poller`

States: IDLE, ISSUE_READ, WAIT_DATA, CHECK, CONFIRM_READ, DONE, FAIL. Transitions:
- IDLE→ISSUE_READ on start.
- ISSUE_READ→WAIT_DATA while status reads remain.
- ISSUE_READ→FAIL when the limit is used up (timeout).
- WAIT_DATA→CHECK when a status word arrives.
- WAIT_DATA→DONE when the confirming word matches.
- WAIT_DATA→FAIL when the confirming word mismatches.
- CHECK→CONFIRM_READ when the flag matches.
- CHECK→ISSUE_READ when the flag does not match.
- CONFIRM_READ→WAIT_DATA.
- DONE→IDLE.
- FAIL→IDLE.

## Requirements
- R1: After reset, and until a start pulse, rd_req_o, done_o, pass_o, timeout_o and busy_o are all 0, and no read is requested.
- R2: For a program (op_erase_i=0), status reads repeat while bit 7 of the returned word differs from bit 7 of exp_data_i.
- R3: For an erase (op_erase_i=1), the flag target on bit 7 is 1, and a returned bit 7 of 0 means still busy.
- R4: Once a status word shows the target flag, exactly one more read is made. Only that confirming word decides the result, so a successful run makes N+2 reads when N busy words precede the flag.
- R5: pass_o is 1 only if the confirming word equals exp_data_i (program) or 32'hFFFFFFFF (erase). On a mismatch, done_o pulses with pass_o=0 and timeout_o=0.
- R6: If poll_limit_i status reads pass without a flag match, done_o pulses with timeout_o=1 and pass_o=0, and exactly poll_limit_i reads are made. A limit of 0 times out with no read at all.
- R7: rd_req_o stays high until a cycle with rd_ack_i=1 and falls in the cycle after it. It then stays low for at least one cycle before the next request.
- R8: rd_addr_o equals the addr_i captured at start for every read of the run, and is stable while a request is pending.
- R9: A start pulse while a run is active is ignored. The operation, data, address and limit of the run do not change.
- R10: busy_o is 1 from the cycle after start until the result cycle. done_o is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse, taken in IDLE only |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| exp_data_i | input | 32 | Word that was programmed |
| addr_i | input | 20 | Address to poll |
| poll_limit_i | input | 16 | Maximum number of status reads |
| rd_req_o | output | 1 | Read request, held until acknowledge |
| rd_addr_o | output | 20 | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid with it |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Poll run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run passed, valid with done_o |
| timeout_o | output | 1 | Run hit the read limit, valid with done_o |

## Verification
Program runs are tried with both flag polarities (written bit 7 high and low). Each run has several busy words, and the flag-match word has every other bit inverted. A pass therefore shows that the confirming word, not the flag word, was judged. Erase runs with an all-ones and a not-quite-all-ones final word separate the erase target from the program target. A protected-style program with stale data tells a confirm mismatch apart from a timeout. Runs with a limit below the busy count, and a limit of zero, check the read count on timeout. A second start in the middle of a run, with a different address, shows that the captured address and mode hold.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_READ,
        ST_WAIT_DATA,
        ST_CHECK,
        ST_CONFIRM_READ,
        ST_DONE,
        ST_FAIL
    } fdp_state_t;
endpackage

// File: rtl/fdp_read_port.sv
// Request/acknowledge read master: one outstanding read, word captured on ack.
module fdp_read_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              req_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] word_o
);
    logic              req_q;
    logic              valid_q;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            valid_q <= req_q & ack_i;
            if (req_q & ack_i) begin
                req_q  <= 1'b0;
                word_q <= data_i;
            end else if (launch_i) begin
                req_q <= 1'b1;
            end
        end
    end

    assign req_o   = req_q;
    assign valid_o = valid_q;
    assign word_o  = word_q;
endmodule

// File: rtl/fdp_poll_counter.sv
// Counts status reads of one run and flags when the limit is used up.
module fdp_poll_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expired_o = (count_q >= limit_i);
endmodule

// File: rtl/fdp_status_eval.sv
// Decodes the completion flag and the full-word match for the current mode.
module fdp_status_eval #(
    parameter int DATA_W   = 32,
    parameter int FLAG_BIT = 7
) (
    input  logic              erase_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              flag_ok_o,
    output logic              word_ok_o
);
    logic [DATA_W-1:0] target;

    always_comb begin
        target    = erase_i ? {DATA_W{1'b1}} : expect_i;
        flag_ok_o = (word_i[FLAG_BIT] == target[FLAG_BIT]);
        word_ok_o = (word_i == target);
    end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 20,
    parameter int CNT_W    = 16,
    parameter int FLAG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [DATA_W-1:0] exp_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  poll_limit_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              timeout_o
);
    fdp_state_t state_q, state_d;

    logic              erase_q;
    logic [DATA_W-1:0] exp_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  limit_q;
    logic              confirm_q;
    logic              timed_out_q;

    logic              take_start;
    logic              launch;
    logic              step;
    logic              expired;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_word;
    logic              flag_ok;
    logic              word_ok;

    assign take_start = (state_q == ST_IDLE) && start_i;
    assign step       = (state_q == ST_ISSUE_READ) && !expired;
    assign launch     = step || (state_q == ST_CONFIRM_READ);

    fdp_read_port #(.DATA_W(DATA_W)) rd_port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .ack_i   (rd_ack_i),
        .data_i  (rd_data_i),
        .req_o   (rd_req_o),
        .valid_o (rd_valid),
        .word_o  (rd_word)
    );

    fdp_poll_counter #(.CNT_W(CNT_W)) poll_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (take_start),
        .step_i   (step),
        .limit_i  (limit_q),
        .expired_o(expired)
    );

    fdp_status_eval #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) eval_i (
        .erase_i  (erase_q),
        .expect_i (exp_q),
        .word_i   (rd_word),
        .flag_ok_o(flag_ok),
        .word_ok_o(word_ok)
    );

    // Run context, captured once per start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q     <= 1'b0;
            exp_q       <= '0;
            addr_q      <= '0;
            limit_q     <= '0;
            confirm_q   <= 1'b0;
            timed_out_q <= 1'b0;
        end else begin
            if (take_start) begin
                erase_q     <= op_erase_i;
                exp_q       <= exp_data_i;
                addr_q      <= addr_i;
                limit_q     <= poll_limit_i;
                confirm_q   <= 1'b0;
                timed_out_q <= 1'b0;
            end
            if (state_q == ST_CONFIRM_READ) begin
                confirm_q <= 1'b1;
            end
            if ((state_q == ST_ISSUE_READ) && expired) begin
                timed_out_q <= 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ISSUE_READ;
                end
            end
            ST_ISSUE_READ: begin
                state_d = expired ? ST_FAIL : ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (rd_valid) begin
                    if (confirm_q) begin
                        state_d = word_ok ? ST_DONE : ST_FAIL;
                    end else begin
                        state_d = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                state_d = flag_ok ? ST_CONFIRM_READ : ST_ISSUE_READ;
            end
            ST_CONFIRM_READ: begin
                state_d = ST_WAIT_DATA;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            ST_FAIL: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rd_addr_o = addr_q;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        pass_o    = 1'b0;
        timeout_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ISSUE_READ, ST_WAIT_DATA, ST_CHECK, ST_CONFIRM_READ: begin
                busy_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                pass_o = 1'b1;
            end
            ST_FAIL: begin
                done_o    = 1'b1;
                timeout_o = timed_out_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              rd_req_o,
    input logic              rd_ack_i,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              timeout_o
);
    // R1: no read request outside an active run
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);

    // R7: request held until acknowledged
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    // R7: request withdrawn after acknowledge
    assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> !rd_req_o);

    // R8: address stable while a request is pending
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));

    // R5: pass only with done and never with timeout
    assert_pass_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (done_o && !timeout_o));

    // R6: timeout only with done and never with pass
    assert_timeout_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (done_o && !pass_o));

    // R10: done is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: an active run continues to its end, even if start is pulsed
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind flash_done_poller fdp_checker #(.ADDR_W(ADDR_W)) fdp_checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rd_req_o (rd_req_o),
    .rd_ack_i (rd_ack_i),
    .rd_addr_o(rd_addr_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pass_o   (pass_o),
    .timeout_o(timeout_o)
);

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_erase_i = 1'b0;
    logic [31:0] exp_data_i = '0;
    logic [19:0] addr_i = '0;
    logic [15:0] poll_limit_i = '0;
    logic        rd_req_o;
    logic [19:0] rd_addr_o;
    logic        rd_ack_i;
    logic [31:0] rd_data_i;
    logic        busy_o, done_o, pass_o, timeout_o;

    always #2 clk = ~clk;   // 250 MHz

    flash_done_poller dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .exp_data_i(exp_data_i), .addr_i(addr_i), .poll_limit_i(poll_limit_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .timeout_o(timeout_o)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic        m_erase = 1'b0;
    logic [31:0] m_exp = '0;
    int          m_busy = 0;
    logic [31:0] m_final = '0;
    int          m_delay = 0;
    logic [19:0] m_addr = '0;
    int          base_reads = 0;
    int          reads = 0;
    int          addr_err = 0;
    int          hs_err = 0;
    int          wcnt = 0;
    logic        ack_q = 1'b0;
    logic [31:0] data_q = '0;
    logic        prev_req = 1'b0;
    logic        prev_ack = 1'b0;

    assign rd_ack_i  = ack_q;
    assign rd_data_i = data_q;

    function automatic logic [31:0] word_for(input int r);
        logic        tgt;
        logic [31:0] w;
        tgt = m_erase ? 1'b1 : m_exp[7];
        if (r < m_busy) begin
            w    = (m_erase ? 32'h5A5A_0000 : m_exp) ^ (32'h0001_0003 * r);
            w[7] = ~tgt;
        end else if (r == m_busy) begin
            w    = ~m_final;
            w[7] = tgt;
        end else begin
            w = m_final;
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            wcnt  <= 0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
            wcnt  <= 0;
        end else if (rd_req_o) begin
            if (wcnt >= m_delay) begin
                ack_q  <= 1'b1;
                data_q <= word_for(reads - base_reads);
                reads  <= reads + 1;
                if (rd_addr_o != m_addr) addr_err <= addr_err + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        // R7 monitor: request must not fall without an acknowledge
        if (rst_n && prev_req && !prev_ack && !rd_req_o) hs_err <= hs_err + 1;
        prev_req <= rd_req_o;
        prev_ack <= ack_q;
    end

    // ---------------- one poll run ----------------
    task automatic run_case(input logic er, input logic [31:0] ex, input int bz,
                            input logic [31:0] fn, input int lm, input int dl,
                            input logic [19:0] ad, input bit restart, input string tag);
        int  n;
        int  a0, h0;
        bit  exp_to, exp_pass;
        int  exp_reads;
        exp_to    = (bz >= lm);
        exp_reads = exp_to ? lm : bz + 2;
        exp_pass  = !exp_to && (fn == (er ? 32'hFFFF_FFFF : ex));
        @(negedge clk);
        m_erase = er; m_exp = ex; m_busy = bz; m_final = fn;
        m_delay = dl; m_addr = ad;
        base_reads = reads; a0 = addr_err; h0 = hs_err;
        op_erase_i = er; exp_data_i = ex; addr_i = ad; poll_limit_i = 16'(lm);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {"R10 busy after start ", tag}, busy_o, 1);
        if (restart) begin
            repeat (2) @(negedge clk);
            op_erase_i = ~er; exp_data_i = ~ex; addr_i = ~ad; poll_limit_i = 16'd1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) begin
            chk(1'b0, {"watchdog ", tag}, n, 0);
            return;
        end
        chk(pass_o == exp_pass, {"R5 pass ", tag}, pass_o, exp_pass);
        chk(timeout_o == exp_to, {"R6 timeout ", tag}, timeout_o, exp_to);
        chk((reads - base_reads) == exp_reads, {"R2 R3 R4 read count ", tag},
            reads - base_reads, exp_reads);
        chk(addr_err == a0, {"R8 address ", tag}, addr_err - a0, 0);
        chk(hs_err == h0, {"R7 handshake ", tag}, hs_err - h0, 0);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, {"R10 done single cycle ", tag},
            {done_o, busy_o}, 0);
    endtask

    // erase, exp, busy count, final word, limit, ack delay
    typedef struct packed {
        logic        er;
        logic [31:0] ex;
        logic [7:0]  bz;
        logic [31:0] fn;
        logic [7:0]  lm;
        logic [3:0]  dl;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 32'h0000_0080, 8'd3, 32'h0000_0080, 8'd10, 4'd0},  // R2 flag high
        '{1'b0, 32'h1234_5600, 8'd5, 32'h1234_5600, 8'd20, 4'd2},  // R2 flag low
        '{1'b1, 32'h0000_0000, 8'd4, 32'hFFFF_FFFF, 8'd10, 4'd1},  // R3 erase pass
        '{1'b0, 32'hDEAD_BEEF, 8'd0, 32'hDEAD_BEEE, 8'd8,  4'd0},  // R5 stale data
        '{1'b1, 32'h0000_0000, 8'd2, 32'hFFFF_7FFF, 8'd8,  4'd3},  // R5 erase mismatch
        '{1'b0, 32'hA5A5_00FF, 8'd9, 32'hA5A5_00FF, 8'd4,  4'd1},  // R6 timeout
        '{1'b0, 32'h0F0F_0F8F, 8'd6, 32'h0F0F_0F8F, 8'd7,  4'd0}   // R4 flag on last read
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({rd_req_o, done_o, pass_o, timeout_o, busy_o} == 5'b0, "R1 in reset",
            {rd_req_o, done_o, pass_o, timeout_o, busy_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({rd_req_o, done_o, pass_o, timeout_o, busy_o} == 5'b0, "R1 idle after reset",
            {rd_req_o, done_o, pass_o, timeout_o, busy_o}, 0);
        chk(reads == 0, "R1 no read before start", reads, 0);

        foreach (VECS[i]) begin
            run_case(VECS[i].er, VECS[i].ex, int'(VECS[i].bz), VECS[i].fn,
                     int'(VECS[i].lm), int'(VECS[i].dl), 20'h1_0000 + 20'(i * 32),
                     1'b0, $sformatf("vec%0d", i));
        end

        // R6 zero limit: timeout with no read
        run_case(1'b0, 32'h0000_0011, 2, 32'h0000_0011, 0, 0, 20'h0_0042, 1'b0, "r6_zero_limit");
        // R9 second start mid-run is ignored
        run_case(1'b1, 32'h0, 5, 32'hFFFF_FFFF, 12, 2, 20'h3_3333, 1'b1, "r9_restart");
        // R2 long poll with slow acks
        run_case(1'b0, 32'h7777_0001, 40, 32'h7777_0001, 100, 5, 20'hF_FFFF, 1'b0, "r2_long");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule